// File: doc/BRIEF.md
# Serial Command Receiver and Control Register File

This block takes commands from a three-wire serial link (active-low select, shift clock, data) and stores them in a bank of control registers. The display logic reads these registers in parallel. All three serial lines are oversampled by the system clock through synchronizers, so the serial clock can be fully asynchronous to the system clock. A word is collected while select is low. On the rising edge of select it is committed, but only if it is well formed. The word's leading five bits pick the destination register.

The serial select line also releases the block from power-on reset. After the asynchronous reset goes away, the block ignores the serial port until it first sees select low. That first select period only performs the release, and any bits sent during it are thrown away. A separate active-low test input then acts as a soft reset. It returns every register to its default and aborts a word that is only partly received.

Top module: `serial_cmd_regfile`

## Requirements
- R1: While `rst_n` is low and right after it rises, every register reads zero on `cfg_regs`, `disp_en` is 0 and `por_done` is 0.
- R2: After `rst_n` rises, the first time `cs_n` is low sets `por_done` to 1, and `por_done` stays 1 until `rst_n` falls. No word sent during that first select period is stored. Registers stay zero while `por_done` is 0.
- R3: Once `por_done` is 1, each select period (`cs_n` low) collects bits from `sdi` on rising edges of `sck`, most significant bit first. Edges of `sck` while `cs_n` is high are not collected.
- R4: A committed 16-bit word whose bit 15 is 1 carries a command number in bits 14:11 and a payload in bits 10:0. For numbers 0 to 13, the payload is written to register N, which appears on `cfg_regs[N*11 +: 11]`. All other registers keep their values.
- R5: Command numbers 14 and 15 (leading code 11110 and 11111) are reserved. A word carrying either one changes no register.
- R6: A select period is committed only if exactly 16 `sck` rising edges arrived before `cs_n` rose. A select period with 15 or with 17 edges changes no register.
- R7: A well-formed 16-bit word whose bit 15 is 0 changes no register.
- R8: `disp_en` equals bit 0 of register 4. It is 0 after any reset, so the display starts switched off.
- R9: Holding `test_n` low after `por_done` is 1 returns every register to zero and discards a word in progress. Bits of that select period received after the pulse are also ignored. `por_done` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Serial select, active low; also releases power-on reset |
| sck | input | 1 | Serial shift clock, data taken on rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| test_n | input | 1 | Active-low soft reset, honoured only after release |
| cfg_regs | output | 154 | All 14 control registers, 11 bits each, register N at bits N*11 |
| disp_en | output | 1 | Display enable, bit 0 of register 4 |
| por_done | output | 1 | High once power-on reset has been released by select |

## Verification
The bench first sends valid words to the lowest, highest and display-control command numbers, with payloads of all ones, single bits and alternating bits, so that a wrong field position or register index shows up as a misplaced value. Next come words that must be dropped: reserved numbers 14 and 15, a word with its top bit clear, and frames one bit short and one bit long. Each of these must leave the register bank exactly as the previous check found it. This separates code decoding from bit counting. Directed cases cover the discarded first select period that performs the release, a plain soft-reset pulse, and a soft-reset pulse in the middle of a frame. The last one must both clear the registers and stop the rest of that frame from landing.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int WORD_BITS  = 16;
  localparam int CMD_BITS   = 4;
  localparam int DATA_BITS  = WORD_BITS - 1 - CMD_BITS;
  localparam int REG_COUNT  = 14;
  localparam int DISP_REG   = 4;
  localparam int DISP_BIT   = 0;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/serial_cmd_sync.sv
module serial_cmd_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_next
        always_comb stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              enable,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int SAT   = WORD_W + 1;
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic              cs_q, sck_q;
  logic              armed_q, armed_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              vld_q, vld_d;
  logic              cs_fall, cs_rise, sck_rise;

  always_comb begin
    cs_fall  = cs_q & ~cs_n_s;
    cs_rise  = ~cs_q & cs_n_s;
    sck_rise = sck_s & ~sck_q;
  end

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    vld_d   = 1'b0;
    if (soft_clr) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (cs_fall && enable) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (cs_rise) begin
      armed_d = 1'b0;
      vld_d   = armed_q && (cnt_q == CNT_W'(WORD_W));
    end else if (armed_q && !cs_n_s && sck_rise) begin
      sh_d = {sh_q[WORD_W-2:0], sdi_s};
      if (cnt_q != CNT_W'(SAT)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      vld_q   <= 1'b0;
    end else begin
      cs_q    <= cs_n_s;
      sck_q   <= sck_s;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      vld_q   <= vld_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = sh_q;

  // R6: bit counter never runs past its saturation value
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SAT));
  // R3: nothing is shifted while select is idle high
  assert_idle_no_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && cs_q) |=> $stable(sh_q));
  // R2: no word is offered before release
  assert_no_word_unreleased_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !vld_q);
endmodule

// File: rtl/serial_cmd_bank.sv
module serial_cmd_bank #(
  parameter int WORD_W = 16,
  parameter int CMD_W  = 4,
  parameter int DATA_W = 11,
  parameter int NREG   = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               word_vld,
  input  logic [WORD_W-1:0]  word,
  output logic [NREG*DATA_W-1:0] cfg
);
  logic [CMD_W-1:0]  num;
  logic [DATA_W-1:0] payload;
  logic              is_cmd;
  logic [NREG-1:0]   wr_en;

  always_comb begin
    is_cmd  = word[WORD_W-1];
    num     = word[WORD_W-2 -: CMD_W];
    payload = word[DATA_W-1:0];
  end

  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_reg
      logic [DATA_W-1:0] r_q, r_d;
      always_comb wr_en[k] = word_vld && is_cmd && (num == CMD_W'(k));
      always_comb begin
        r_d = r_q;
        if (soft_clr)      r_d = '0;
        else if (wr_en[k]) r_d = payload;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
      end
      assign cfg[k*DATA_W +: DATA_W] = r_q;
    end
  endgenerate

  // R4: at most one register written per word
  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  // R5: reserved command numbers leave the bank untouched
  assert_reserved_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && is_cmd && num >= CMD_W'(NREG) && !soft_clr) |=> $stable(cfg));
  // R7: words with top bit clear leave the bank untouched
  assert_non_cmd_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !is_cmd && !soft_clr) |=> $stable(cfg));
  // R9: soft reset empties the bank
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cfg == '0));
endmodule

// File: rtl/serial_cmd_regfile.sv
module serial_cmd_regfile
  import serial_cmd_pkg::*;
#(
  parameter int WORD_W = WORD_BITS,
  parameter int CMD_W  = CMD_BITS,
  parameter int NREG   = REG_COUNT,
  parameter int DREG   = DISP_REG,
  parameter int DBIT   = DISP_BIT,
  parameter int SYNC_N = SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic test_n,
  output logic [NREG*(WORD_W-1-CMD_W)-1:0] cfg_regs,
  output logic disp_en,
  output logic por_done
);
  localparam int DATA_W = WORD_W - 1 - CMD_W;

  logic [3:0]        raw, syn;
  logic              cs_s, sck_s, sdi_s, test_s;
  logic              rel_q, rel_d;
  logic              soft_clr;
  logic              word_vld;
  logic [WORD_W-1:0] word;

  assign raw = {test_n, sdi, sck, cs_n};

  serial_cmd_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_comb begin
    cs_s   = syn[0];
    sck_s  = syn[1];
    sdi_s  = syn[2];
    test_s = syn[3];
  end

  always_comb begin
    rel_d    = rel_q | ~cs_s;
    soft_clr = rel_q & ~test_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= rel_d;
  end

  serial_cmd_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .enable(rel_q),
    .cs_n_s(cs_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .word_vld(word_vld), .word(word)
  );

  serial_cmd_bank #(.WORD_W(WORD_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .word_vld(word_vld), .word(word), .cfg(cfg_regs)
  );

  assign disp_en  = cfg_regs[DREG*DATA_W + DBIT];
  assign por_done = rel_q;

  // R2: once released, stays released until power-on reset
  assert_release_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> rel_q);
  // R2: bank is empty until release
  assert_empty_until_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_q |-> (cfg_regs == '0));
  // R8: display stays off until released
  assert_disp_off_unreleased_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_q |-> !disp_en);
endmodule

// File: tb/tb_serial_cmd_regfile.sv
module tb_serial_cmd_regfile;
  localparam int CLK_P  = 10;
  localparam int HALF   = 4;
  localparam int NREG   = 14;
  localparam int DW     = 11;
  localparam int NVEC   = 12;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, sdi, test_n;
  logic [NREG*DW-1:0] cfg_regs;
  logic disp_en, por_done;

  int total = 0;
  int fails = 0;
  logic [DW-1:0] model [NREG];

  always #(CLK_P/2) clk = ~clk;

  serial_cmd_regfile dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .test_n(test_n),
    .cfg_regs(cfg_regs), .disp_en(disp_en), .por_done(por_done)
  );

  // {bit count, word}
  typedef logic [20:0] vec_t;
  localparam vec_t VECS [NVEC] = '{
    {5'd16, 16'hA001},  // cmd 4 payload 1 -> display on
    {5'd16, 16'h85A5},  // cmd 0
    {5'd16, 16'hEFFF},  // cmd 13 all ones
    {5'd16, 16'hF123},  // reserved 14
    {5'd16, 16'hF804},  // reserved 15
    {5'd15, 16'h8911},  // short frame
    {5'd17, 16'h8933},  // long frame
    {5'd16, 16'h2555},  // top bit clear
    {5'd16, 16'hBAAA},  // cmd 7
    {5'd16, 16'hA3FE},  // cmd 4 bit0 clear -> display off
    {5'd16, 16'h88F0},  // cmd 1
    {5'd16, 16'h8001}   // cmd 0 overwrite
  };

  function automatic string tag_of(input logic [15:0] w, input int n);
    if (n != 16)               return "R6";
    if (!w[15])                return "R7";
    if (w[14:11] >= 4'd14)     return "R5";
    if (w[14:11] == 4'd4)      return "R8";
    return "R4";
  endfunction

  task automatic model_apply(input logic [15:0] w, input int n);
    if (n == 16 && w[15] && w[14:11] < 4'd14) model[w[14:11]] = w[10:0];
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int n, input bit pulse_mid);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      if (pulse_mid && i == 8) begin
        test_n = 1'b0;
        tick(6);
        test_n = 1'b1;
      end
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(10);
  endtask

  task automatic check(input string tag, input logic exp_por);
    logic [NREG*DW-1:0] exp_flat;
    for (int k = 0; k < NREG; k++) exp_flat[k*DW +: DW] = model[k];
    total++;
    if (cfg_regs !== exp_flat || disp_en !== model[4][0] || por_done !== exp_por) begin
      fails++;
      $display("FAIL %s: actual cfg=%h disp=%b por=%b expected cfg=%h disp=%b por=%b",
               tag, cfg_regs, disp_en, por_done, exp_flat, model[4][0], exp_por);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog R1: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = '0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; test_n = 1'b1;
    tick(3);
    check("R1", 1'b0);
    rst_n = 1'b1;
    tick(5);
    check("R1", 1'b0);

    // First select only releases; its word is dropped (R2)
    send(16'hA001, 16, 1'b0);
    check("R2", 1'b1);

    // Main table (R3, R4..R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] w;
      int n;
      w = VECS[v][15:0];
      n = int'(VECS[v][20:16]);
      send(w, n, 1'b0);
      model_apply(w, n);
      check(tag_of(w, n), 1'b1);
    end

    // Plain soft reset (R9)
    test_n = 1'b0;
    tick(6);
    test_n = 1'b1;
    tick(6);
    for (int k = 0; k < NREG; k++) model[k] = '0;
    check("R9", 1'b1);

    // Load a value, then soft reset in mid frame (R9, R3)
    send(16'h8001, 16, 1'b0);
    model_apply(16'h8001, 16);
    check("R3", 1'b1);
    send(16'h8802, 16, 1'b1);
    for (int k = 0; k < NREG; k++) model[k] = '0;
    check("R9", 1'b1);

    // Port still usable after soft reset (R4)
    send(16'hE805, 16, 1'b0);
    model_apply(16'hE805, 16);
    check("R4", 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule